// File: doc/BRIEF.md
# Chipset Configuration and Shadow-Memory Router

This block holds the configuration registers of a 486-class system chipset. Software reaches them through two bytes of an 8-bit I/O space. A pointer port selects a register and an access port reads or writes the selected register. Six of the registers are shadow controls. Each one divides a 64 KB group of the upper memory area (A0000h–FFFFFh) into four 16 KB segments. For every segment, reads and writes are sent independently either to the ROM/expansion bus or to on-board RAM.

The block drives a pair of 24-bit segment vectors, one for reads and one for writes, that say which segments are served from internal RAM. It also offers a combinational lookup. The memory controller gives it a 20-bit address and a direction, and the lookup answers whether that access targets internal RAM. Two side ports complete the block. One switches the fast gate for address line 20 on or off. The other starts a processor soft reset.

Top module: `chipset_shadow_cfg`

## Requirements
- R1: Writing port ECh loads the 8-bit register pointer. Reading ECh returns the pointer, which is 00h after reset.
- R2: With the pointer at 00h, a read of port EDh returns 90h. Writes to that index are discarded.
- R3: A write to EDh is stored only when the pointer is in 01h–24h, and a read of EDh at those indices returns the stored byte. Writes at any other pointer value change nothing. Reads at pointers above 24h return 00h.
- R4: After reset, every stored register is 00h. All 48 bits of the two segment vectors are therefore 0 (external).
- R5: Shadow registers 0Dh–12h cover the groups at A0000h, B0000h, C0000h, D0000h, E0000h and F0000h, in that order. In each register, bits [1:0], [3:2], [5:4] and [7:6] cover the 16 KB segments at offsets 0000h, 4000h, 8000h and C000h. Segment number s = 4·group + field drives bit s of both vectors.
- R6: The upper bit of a field enables internal reads, and the lower bit enables internal writes. Code 0 is all external. Code 1 writes internally and reads externally. Code 2 reads internally and writes externally. Code 3 is all internal.
- R7: `mem_internal` is combinational. It is 0 for addresses below A0000h. Otherwise it is the read or write bit of the segment that holds the address, with the direction chosen by `mem_we` (1 = write).
- R8: A register write changes the segment vectors on the clock edge that accepts it, and not before.
- R9: After a read of port EEh, `a20_gate` is 1 from the next clock edge. After a write of EEh, it is 0. When EEh is read and written in the same cycle, the clear wins. The reset value is 0.
- R10: A read of port EFh makes `cpu_reset` high for exactly one cycle, starting at the next clock edge.
- R11: Reads of any port other than ECh and EDh, including EEh and EFh, return FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port address (low byte) |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational |
| mem_addr | input | 20 | Memory address for the route lookup |
| mem_we | input | 1 | Lookup direction, 1 = write |
| mem_internal | output | 1 | Lookup result, 1 = internal RAM |
| seg_rd_int | output | 24 | Per-segment internal-read enables, bit 0 = A0000h |
| seg_wr_int | output | 24 | Per-segment internal-write enables, bit 0 = A0000h |
| a20_gate | output | 1 | Fast A20 gate level |
| cpu_reset | output | 1 | Soft-reset pulse |

## Verification
The A20 side port can receive a set and a clear in the same cycle, because a read and a write strobe can both hit EEh. The bench first sets the gate, then drives both strobes on EEh for one cycle, and expects the gate to read 0 after the edge. A second collision happens when a shadow register is rewritten while the lookup is probing that register's segment. The bench samples the lookup before the accepting edge and expects the old route, then samples after the edge and expects the new one.

// File: rtl/chipset_shadow_cfg.sv
module chipset_shadow_cfg #(
  parameter logic [7:0] PTR_PORT   = 8'hEC,
  parameter logic [7:0] DATA_PORT  = 8'hED,
  parameter logic [7:0] A20_PORT   = 8'hEE,
  parameter logic [7:0] RST_PORT   = 8'hEF,
  parameter logic [7:0] ID_VALUE   = 8'h90,
  parameter int         LAST_IDX   = 36,
  parameter int         SHADOW_IDX = 13,
  parameter int         GROUPS     = 6,
  parameter int         FIELDS     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [19:0] mem_addr,
  input  logic        mem_we,
  output logic        mem_internal,
  output logic [23:0] seg_rd_int,
  output logic [23:0] seg_wr_int,
  output logic        a20_gate,
  output logic        cpu_reset
);
  localparam int NSEG      = GROUPS * FIELDS;
  localparam int FIRST_BLK = 64 - NSEG;

  logic [7:0] ptr;
  logic [7:0] cfg [0:LAST_IDX];

  wire ptr_ok   = (ptr >= 8'd1) && (ptr <= 8'(LAST_IDX));
  wire data_wr  = io_wr && (io_addr == DATA_PORT);
  wire a20_clr  = io_wr && (io_addr == A20_PORT);
  wire a20_set  = io_rd && (io_addr == A20_PORT);
  wire rst_hit  = io_rd && (io_addr == RST_PORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= 8'h00;
      a20_gate  <= 1'b0;
      cpu_reset <= 1'b0;
      for (int i = 0; i <= LAST_IDX; i++) cfg[i] <= 8'h00;
    end else begin
      cpu_reset <= rst_hit;
      if (io_wr && io_addr == PTR_PORT) ptr <= io_wdata;
      if (data_wr && ptr_ok) cfg[ptr[5:0]] <= io_wdata;
      if (a20_clr)      a20_gate <= 1'b0;
      else if (a20_set) a20_gate <= 1'b1;
    end
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (io_addr == PTR_PORT) io_rdata = ptr;
    else if (io_addr == DATA_PORT) begin
      if (ptr == 8'h00)   io_rdata = ID_VALUE;
      else if (ptr_ok)    io_rdata = cfg[ptr[5:0]];
      else                io_rdata = 8'h00;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar k = 0; k < FIELDS; k++) begin : g_fld
      assign seg_rd_int[g*FIELDS+k] = cfg[SHADOW_IDX+g][2*k+1];
      assign seg_wr_int[g*FIELDS+k] = cfg[SHADOW_IDX+g][2*k];
    end
  end

  wire [5:0] blk   = mem_addr[19:14];
  wire       upper = blk >= 6'(FIRST_BLK);
  wire [4:0] seg   = 5'(blk - 6'(FIRST_BLK));
  assign mem_internal = upper && (mem_we ? seg_wr_int[seg] : seg_rd_int[seg]);

  // R10
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |-> $past(io_rd && io_addr == RST_PORT));
  // R9
  a20_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == A20_PORT) |=> !a20_gate);
  // R9
  a20_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == A20_PORT && !(io_wr && io_addr == A20_PORT)) |=> a20_gate);
  // R2
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == DATA_PORT && ptr == 8'h00) |-> io_rdata == ID_VALUE);
  // R3
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ptr_ok && !(io_wr && io_addr == PTR_PORT)) |=>
      ($stable(seg_rd_int) && $stable(seg_wr_int)));
  // R7
  low_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr < 20'hA0000) |-> !mem_internal);
endmodule

// File: tb/chipset_shadow_cfg_test.sv
module chipset_shadow_cfg_test;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  io_addr = 0, io_wdata = 0, io_rdata;
  logic        io_wr = 0, io_rd = 0;
  logic [19:0] mem_addr = 0;
  logic        mem_we = 0, mem_internal;
  logic [23:0] seg_rd_int, seg_wr_int;
  logic        a20_gate, cpu_reset;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [0:5];

  always #4 clk = ~clk;

  chipset_shadow_cfg uut (.*);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic io_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1; #1 d = io_rdata;
    @(negedge clk); io_rd = 0;
  endtask

  function automatic logic [23:0] exp_vec(bit rd);
    logic [23:0] v;
    for (int s = 0; s < 24; s++) begin
      logic [1:0] c = 2'((model[s/4] >> (2*(s%4))) & 8'h3);
      v[s] = rd ? c[1] : c[0];
    end
    return v;
  endfunction

  task automatic probe(logic [19:0] a, bit we, string req);
    logic e;
    mem_addr = a; mem_we = we; #1;
    if (a < 20'hA0000) e = 0;
    else begin
      int s = int'(a >> 14) - 40;
      logic [1:0] c = 2'((model[s/4] >> (2*(s%4))) & 8'h3);
      e = we ? c[0] : c[1];
    end
    chk(mem_internal === e, req, 32'(mem_internal), 32'(e));
  endtask

  initial begin
    #(8*200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    for (int g = 0; g < 6; g++) model[g] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R4 reset state
    @(negedge clk);
    chk(seg_rd_int == 0 && seg_wr_int == 0, "R4", {seg_rd_int[15:0], seg_wr_int[15:0]}, 0);
    chk(a20_gate == 0 && cpu_reset == 0, "R9", {a20_gate, cpu_reset}, 0);
    io_read(8'hEC, r); chk(r == 8'h00, "R1", r, 0);
    // R2 ID register
    io_read(8'hED, r); chk(r == 8'h90, "R2", r, 8'h90);
    io_write(8'hED, 8'h33);
    io_read(8'hED, r); chk(r == 8'h90, "R2", r, 8'h90);
    // R1 R3 sweep every index
    for (int i = 0; i < 256; i++) begin
      logic [7:0] v = 8'(i) ^ 8'hA5;
      logic [7:0] e;
      io_write(8'hEC, 8'(i));
      io_read(8'hEC, r); chk(r == 8'(i), "R1", r, i);
      io_write(8'hED, v);
      if (i >= 13 && i <= 18) model[i-13] = v;
      e = (i == 0) ? 8'h90 : (i <= 36) ? v : 8'h00;
      io_read(8'hED, r); chk(r == e, "R3", r, e);
      chk(seg_rd_int == exp_vec(1) && seg_wr_int == exp_vec(0), "R3",
          {seg_rd_int[15:0], seg_wr_int[15:0]}, {exp_vec(1)[15:0], exp_vec(0)[15:0]});
    end
    // R5 R6 R7 R8 exhaustive codes per shadow register
    for (int g = 0; g < 6; g++) begin
      io_write(8'hEC, 8'(13 + g));
      for (int v = 0; v < 256; v++) begin
        logic [19:0] base = 20'hA0000 + 20'(g) * 20'h10000;
        @(negedge clk); io_addr = 8'hED; io_wdata = 8'(v); io_wr = 1;
        probe(base + 20'h4123, 0, "R8");
        @(posedge clk); #1 io_wr = 0;
        model[g] = 8'(v);
        chk(seg_rd_int == exp_vec(1), "R5", seg_rd_int, exp_vec(1));
        chk(seg_wr_int == exp_vec(0), "R6", seg_wr_int, exp_vec(0));
        for (int k = 0; k < 4; k++) begin
          probe(base + 20'(k) * 20'h4000, 0, "R7");
          probe(base + 20'(k) * 20'h4000 + 20'h3FFF, 1, "R7");
        end
      end
    end
    probe(20'h9FFFF, 0, "R7"); probe(20'h9FFFF, 1, "R7");
    probe(20'h00000, 1, "R7"); probe(20'h5C000, 0, "R7");
    // R9 A20
    io_read(8'hEE, r); chk(r == 8'hFF, "R11", r, 8'hFF);
    chk(a20_gate == 1, "R9", a20_gate, 1);
    io_write(8'hEE, 8'h00); chk(a20_gate == 0, "R9", a20_gate, 0);
    io_read(8'hEE, r);
    @(negedge clk); io_addr = 8'hEE; io_rd = 1; io_wr = 1;
    @(negedge clk); io_rd = 0; io_wr = 0;
    chk(a20_gate == 0, "R9", a20_gate, 0);
    // R10 soft reset pulse
    @(negedge clk); io_addr = 8'hEF; io_rd = 1; #1 r = io_rdata;
    chk(r == 8'hFF, "R11", r, 8'hFF);
    chk(cpu_reset == 0, "R10", cpu_reset, 0);
    @(negedge clk); io_rd = 0;
    chk(cpu_reset == 1, "R10", cpu_reset, 1);
    @(negedge clk); chk(cpu_reset == 0, "R10", cpu_reset, 0);
    // R11 other ports
    for (int p = 0; p < 256; p += 17) begin
      if (p != 8'hEC && p != 8'hED) begin
        io_read(8'(p), r); chk(r == 8'hFF, "R11", r, 8'hFF);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule